// File: doc/BRIEF.md
# Prioritized Conversion Trigger Arbiter

This block sits in front of an ADC conversion sequencer and decides which of several trigger sources may launch a command. Every source has two request paths. One is a hardware input that is edge-detected and can be switched off. The other is a software write mask with one bit per source. Requests are held in a pending set until they are serviced. Each source carries its own configuration: the command number it launches, a hardware-path enable, a one-bit priority and a four-bit delay exponent.

When the arbiter is idle it takes the best pending request. Priority 0 beats priority 1, and among equal priorities the lower index wins. It waits the requested delay, then pulses a start to the sequencer and reports the active trigger and command. A running chain ends when the sequencer reports completion. A strictly higher-priority request that arrives while a chain runs preempts it, under one of two policies. In the hard policy the chain is aborted at once. In the graceful policy a stop request is raised and the arbiter waits until the conversion in flight has been stored.

Top module: `trig_arb`

## Requirements
- R1: While rst_ni is low and after its release, start_o, abort_o and soft_stop_o are 0, act_trig_o and act_cmd_o are 0, and no request is pending.
- R2: Bit i of hw_trig_i raises a request for source i only on a 0-to-1 transition and only while cfg_hw_en_i[i] is 1. A held high level or a disabled input raises nothing.
- R3: When sw_trig_we_i is 1, bit i of sw_trig_i requests source i. While enable_i is 0, requests from both paths are discarded.
- R4: From idle, the arbiter takes the pending source whose cfg_prio_i bit is 0 with the lowest index. If no such source is pending, it takes the pending source with priority 1 and the lowest index.
- R5: A source with delay field d = cfg_dly_i[4i+3:4i] raises start_o in the cycle after it is taken when d is 0. When d is not 0, start_o comes 2^d cycles later than that.
- R6: With soft_preempt_i at 0, a running priority-1 chain that sees a pending priority-0 request ends with a one-cycle abort_o pulse. In that same cycle the status outputs return to 0, and the best pending request is launched next.
- R7: With soft_preempt_i at 1, the same situation raises soft_stop_o and holds it, with the status unchanged, until seq_conv_done_i or seq_done_i. Then the arbiter goes idle and launches the best pending request.
- R8: A pending request of equal or lower priority never interrupts a running chain. It waits until seq_done_i.
- R9: A request for a source that is already pending merges into the existing request, and the source is serviced once.
- R10: While running, seq_done_i returns the arbiter to idle. If requests are pending, the best one is taken in the following cycle.
- R11: From the moment a source is taken until the arbiter is idle again, act_trig_o shows the source index plus 1 and act_cmd_o shows that source's configured command (cfg_cmd_i[4i+3:4i]). start_o is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Module enable; gates new requests |
| soft_preempt_i | input | 1 | Preemption policy: 0 abort at once, 1 finish conversion first |
| cfg_cmd_i | input | NUM_TRIG*CMD_W | Command number per source |
| cfg_hw_en_i | input | NUM_TRIG | Hardware path enable per source |
| cfg_prio_i | input | NUM_TRIG | Priority per source, 0 is higher |
| cfg_dly_i | input | NUM_TRIG*DLY_W | Delay exponent per source |
| hw_trig_i | input | NUM_TRIG | Hardware trigger levels |
| sw_trig_i | input | NUM_TRIG | Software request mask |
| sw_trig_we_i | input | 1 | Write strobe for sw_trig_i |
| seq_conv_done_i | input | 1 | Sequencer stored the conversion in flight |
| seq_done_i | input | 1 | Sequencer finished the command chain |
| start_o | output | 1 | Launch pulse to the sequencer |
| abort_o | output | 1 | Immediate abort pulse |
| soft_stop_o | output | 1 | Stop after the current conversion |
| act_trig_o | output | $clog2(NUM_TRIG+1) | Active source index plus 1, 0 when idle |
| act_cmd_o | output | CMD_W | Active command number, 0 when idle |

## Verification
The hardest condition to reach is graceful preemption. It needs a priority-1 chain already running, a priority-0 request arriving in the middle of it, and the policy input set before that request arrives. The stimulus first launches a low-priority source with zero delay and lets it settle in the running state. It then writes the high-priority software bit and holds off the conversion-done pulse for several cycles, so that the held stop request and the frozen status can be observed before the handover. A behavioural model driven by the same inputs predicts every output on every cycle, including the cycle in which the preempting source is taken.

// File: rtl/trig_arb_pkg.sv
package trig_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_RUN   = 2'd2,
    ST_DRAIN = 2'd3
  } arb_state_e;
endpackage

// File: rtl/trig_arb_capture.sv
module trig_arb_capture #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [N-1:0] hw_i,
  input  logic [N-1:0] hw_en_i,
  input  logic [N-1:0] sw_i,
  input  logic         sw_we_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] hw_q, pend_q, req;

  always_comb begin
    req = ((hw_i & ~hw_q & hw_en_i) | (sw_i & {N{sw_we_i}})) & {N{en_i}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hw_q   <= '0;
      pend_q <= '0;
    end else begin
      hw_q   <= hw_i;
      // a new request in the cycle of service re-arms the source
      pend_q <= (pend_q & ~clr_i) | req;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/trig_arb_pick.sv
module trig_arb_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     pend_i,
  input  logic [N-1:0]     prio_i,
  output logic             any_o,
  output logic             hi_any_o,
  output logic [IDX_W-1:0] win_o
);
  logic [N-1:0] hi_req, lo_req, sel;

  always_comb begin
    hi_req   = pend_i & ~prio_i;
    lo_req   = pend_i & prio_i;
    hi_any_o = |hi_req;
    any_o    = |pend_i;
    sel      = hi_any_o ? hi_req : lo_req;
    win_o    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (sel[i]) win_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/trig_arb_launch.sv
module trig_arb_launch
  import trig_arb_pkg::*;
#(
  parameter int N      = 4,
  parameter int CMD_W  = 4,
  parameter int DLY_W  = 4,
  parameter int IDX_W  = 2,
  parameter int TRIG_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_preempt_i,
  input  logic [N*CMD_W-1:0] cfg_cmd_i,
  input  logic [N-1:0]       cfg_prio_i,
  input  logic [N*DLY_W-1:0] cfg_dly_i,
  input  logic               any_i,
  input  logic               hi_any_i,
  input  logic [IDX_W-1:0]   win_i,
  input  logic               seq_conv_done_i,
  input  logic               seq_done_i,
  output logic [N-1:0]       clr_o,
  output logic               start_o,
  output logic               abort_o,
  output logic               soft_stop_o,
  output logic [TRIG_W-1:0]  act_trig_o,
  output logic [CMD_W-1:0]   act_cmd_o
);
  localparam int CNT_W = 1 << DLY_W;

  arb_state_e       state_q;
  logic [IDX_W-1:0] cur_q;
  logic [CMD_W-1:0] cmd_q;
  logic             prio_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start_q, abort_q;
  logic [DLY_W-1:0] win_dly;

  assign win_dly = cfg_dly_i[win_i*DLY_W +: DLY_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      cmd_q   <= '0;
      prio_q  <= 1'b0;
      cnt_q   <= '0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      abort_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (any_i) begin
          cur_q  <= win_i;
          cmd_q  <= cfg_cmd_i[win_i*CMD_W +: CMD_W];
          prio_q <= cfg_prio_i[win_i];
          if (win_dly == '0) begin
            start_q <= 1'b1;
            state_q <= ST_RUN;
          end else begin
            cnt_q   <= (CNT_W'(1) << win_dly) - CNT_W'(1);
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cnt_q == '0) begin
            start_q <= 1'b1;
            state_q <= ST_RUN;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_RUN: begin
          if (seq_done_i) begin
            state_q <= ST_IDLE;
          end else if (prio_q && hi_any_i) begin
            if (soft_preempt_i) begin
              state_q <= ST_DRAIN;
            end else begin
              abort_q <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_DRAIN: if (seq_done_i || seq_conv_done_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign clr_o       = (state_q == ST_IDLE && any_i) ? (N'(1) << win_i) : '0;
  assign start_o     = start_q;
  assign abort_o     = abort_q;
  assign soft_stop_o = (state_q == ST_DRAIN);
  assign act_trig_o  = (state_q != ST_IDLE) ? TRIG_W'(cur_q) + TRIG_W'(1) : '0;
  assign act_cmd_o   = (state_q != ST_IDLE) ? cmd_q : '0;
endmodule

// File: rtl/trig_arb.sv
module trig_arb #(
  parameter int NUM_TRIG = 4,
  parameter int CMD_W    = 4,
  parameter int DLY_W    = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         enable_i,
  input  logic                         soft_preempt_i,
  input  logic [NUM_TRIG*CMD_W-1:0]    cfg_cmd_i,
  input  logic [NUM_TRIG-1:0]          cfg_hw_en_i,
  input  logic [NUM_TRIG-1:0]          cfg_prio_i,
  input  logic [NUM_TRIG*DLY_W-1:0]    cfg_dly_i,
  input  logic [NUM_TRIG-1:0]          hw_trig_i,
  input  logic [NUM_TRIG-1:0]          sw_trig_i,
  input  logic                         sw_trig_we_i,
  input  logic                         seq_conv_done_i,
  input  logic                         seq_done_i,
  output logic                         start_o,
  output logic                         abort_o,
  output logic                         soft_stop_o,
  output logic [$clog2(NUM_TRIG+1)-1:0] act_trig_o,
  output logic [CMD_W-1:0]             act_cmd_o
);
  localparam int IDX_W  = $clog2(NUM_TRIG);
  localparam int TRIG_W = $clog2(NUM_TRIG + 1);

  logic [NUM_TRIG-1:0] pend, clr;
  logic                any, hi_any;
  logic [IDX_W-1:0]    win;

  trig_arb_capture #(.N(NUM_TRIG)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (enable_i),
    .hw_i    (hw_trig_i),
    .hw_en_i (cfg_hw_en_i),
    .sw_i    (sw_trig_i),
    .sw_we_i (sw_trig_we_i),
    .clr_i   (clr),
    .pend_o  (pend)
  );

  trig_arb_pick #(.N(NUM_TRIG), .IDX_W(IDX_W)) u_pick (
    .pend_i   (pend),
    .prio_i   (cfg_prio_i),
    .any_o    (any),
    .hi_any_o (hi_any),
    .win_o    (win)
  );

  trig_arb_launch #(
    .N(NUM_TRIG), .CMD_W(CMD_W), .DLY_W(DLY_W), .IDX_W(IDX_W), .TRIG_W(TRIG_W)
  ) u_launch (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .soft_preempt_i  (soft_preempt_i),
    .cfg_cmd_i       (cfg_cmd_i),
    .cfg_prio_i      (cfg_prio_i),
    .cfg_dly_i       (cfg_dly_i),
    .any_i           (any),
    .hi_any_i        (hi_any),
    .win_i           (win),
    .seq_conv_done_i (seq_conv_done_i),
    .seq_done_i      (seq_done_i),
    .clr_o           (clr),
    .start_o         (start_o),
    .abort_o         (abort_o),
    .soft_stop_o     (soft_stop_o),
    .act_trig_o      (act_trig_o),
    .act_cmd_o       (act_cmd_o)
  );
endmodule

// File: rtl/trig_arb_chk.sv
module trig_arb_chk #(
  parameter int TRIG_W = 3,
  parameter int CMD_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_preempt_i,
  input logic              start_o,
  input logic              abort_o,
  input logic              soft_stop_o,
  input logic [TRIG_W-1:0] act_trig_o,
  input logic [CMD_W-1:0]  act_cmd_o
);
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R11
  AST_START_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> act_trig_o != '0); // R11
  AST_IDLE_NO_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_trig_o == '0 |-> act_cmd_o == '0); // R11
  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> act_trig_o == '0 && !soft_stop_o); // R6
  AST_ABORT_POLICY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !$past(soft_preempt_i)); // R6
  AST_DRAIN_POLICY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(soft_stop_o) |-> $past(soft_preempt_i)); // R7
  AST_DRAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_stop_o |-> act_trig_o != '0); // R7
endmodule

bind trig_arb trig_arb_chk #(.TRIG_W($clog2(NUM_TRIG+1)), .CMD_W(CMD_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .soft_preempt_i (soft_preempt_i),
  .start_o        (start_o),
  .abort_o        (abort_o),
  .soft_stop_o    (soft_stop_o),
  .act_trig_o     (act_trig_o),
  .act_cmd_o      (act_cmd_o)
);

// File: tb/tb_trig_arb.sv
module tb_trig_arb;
  localparam int N = 4;
  localparam int CW = 4;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic enable = 1'b1, soft_pol = 1'b0;
  logic [N*CW-1:0] cfg_cmd;
  logic [N-1:0] hw_en = '0, prio = '0, hw = '0, sw = '0;
  logic [N*DW-1:0] dly = '0;
  logic sw_we = 1'b0, conv_done = 1'b0, seq_done = 1'b0;
  logic start, abort_p, soft_stop;
  logic [2:0] act_trig;
  logic [CW-1:0] act_cmd;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit fin = 1'b0;
  string tag = "R1";

  always #10 clk = ~clk;

  trig_arb dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .soft_preempt_i(soft_pol),
    .cfg_cmd_i(cfg_cmd), .cfg_hw_en_i(hw_en), .cfg_prio_i(prio), .cfg_dly_i(dly),
    .hw_trig_i(hw), .sw_trig_i(sw), .sw_trig_we_i(sw_we),
    .seq_conv_done_i(conv_done), .seq_done_i(seq_done),
    .start_o(start), .abort_o(abort_p), .soft_stop_o(soft_stop),
    .act_trig_o(act_trig), .act_cmd_o(act_cmd)
  );

  // behavioural reference
  int m_state, m_cur, m_cmd, m_prio, m_cnt;
  bit m_start, m_abort;
  bit m_pend[N];
  bit m_hwq[N];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cur = 0; m_cmd = 0; m_prio = 0; m_cnt = 0;
      m_start = 0; m_abort = 0;
      for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_hwq[i] = 0; end
    end else begin
      bit req[N];
      int w, clr, d;
      bit hp;
      for (int i = 0; i < N; i++)
        req[i] = enable && ((hw[i] && !m_hwq[i] && hw_en[i]) || (sw_we && sw[i]));
      w = -1;
      for (int p = 0; p < 2; p++)
        for (int i = 0; i < N; i++)
          if (w < 0 && m_pend[i] && prio[i] == p[0]) w = i;
      hp = 0;
      for (int i = 0; i < N; i++) if (m_pend[i] && !prio[i]) hp = 1;
      clr = -1; m_start = 0; m_abort = 0;
      case (m_state)
        0: if (w >= 0) begin
          m_cur = w; clr = w; m_cmd = int'(cfg_cmd[w*CW +: CW]); m_prio = int'(prio[w]);
          d = int'(dly[w*DW +: DW]);
          if (d == 0) begin m_start = 1; m_state = 2; end
          else begin m_cnt = (1 << d) - 1; m_state = 1; end
        end
        1: if (m_cnt == 0) begin m_start = 1; m_state = 2; end else m_cnt--;
        2: if (seq_done) m_state = 0;
           else if (m_prio == 1 && hp) begin
             if (soft_pol) m_state = 3; else begin m_abort = 1; m_state = 0; end
           end
        default: if (seq_done || conv_done) m_state = 0;
      endcase
      for (int i = 0; i < N; i++) begin
        m_pend[i] = (m_pend[i] && i != clr) || req[i];
        m_hwq[i] = hw[i];
      end
    end
  end

  always @(negedge clk) begin
    if (!fin && cyc > 0) begin
      int e_trig, e_cmd;
      e_trig = (m_state != 0) ? m_cur + 1 : 0;
      e_cmd  = (m_state != 0) ? m_cmd : 0;
      n_chk++;
      if (start !== m_start || abort_p !== m_abort || soft_stop !== (m_state == 3) ||
          int'(act_trig) != e_trig || int'(act_cmd) != e_cmd) begin
        n_fail++;
        $display("FAIL %s t=%0t act st=%b ab=%b ss=%b trig=%0d cmd=%0d exp st=%b ab=%b ss=%b trig=%0d cmd=%0d",
                 tag, $time, start, abort_p, soft_stop, act_trig, act_cmd,
                 m_start, m_abort, m_state == 3, e_trig, e_cmd);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000 && !fin) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired during %s", tag);
      fin = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sw_pulse(input logic [N-1:0] m);
    sw = m; sw_we = 1'b1;
    @(negedge clk);
    sw = '0; sw_we = 1'b0;
  endtask

  task automatic done_pulse();
    seq_done = 1'b1;
    @(negedge clk);
    seq_done = 1'b0;
  endtask

  initial begin
    cfg_cmd = {4'd12, 4'd9, 4'd7, 4'd3};
    #1 rst_n = 1'b0;
    tag = "R1"; wait_cyc(3);
    rst_n = 1'b1; wait_cyc(3);

    tag = "R11"; sw_pulse(4'b0100); wait_cyc(4);
    tag = "R10"; done_pulse(); wait_cyc(3);

    tag = "R3"; enable = 1'b0; sw_pulse(4'b0001); hw_en = 4'b0001; hw = 4'b0001;
    wait_cyc(4); hw = '0; enable = 1'b1; wait_cyc(3);

    tag = "R2"; hw_en = 4'b0010; hw = 4'b0010; wait_cyc(3); done_pulse();
    wait_cyc(4); hw = '0; wait_cyc(2);
    hw = 4'b1000; wait_cyc(3); hw = '0; wait_cyc(2);
    hw = 4'b0010; wait_cyc(3); hw = '0; done_pulse(); wait_cyc(2);

    tag = "R4"; prio = 4'b0001; sw_pulse(4'b1111);
    for (int k = 0; k < 4; k++) begin wait_cyc(3); done_pulse(); end
    wait_cyc(3);

    tag = "R5"; dly[2*DW +: DW] = 4'd3; sw_pulse(4'b0100); wait_cyc(12); done_pulse();
    dly[2*DW +: DW] = 4'd1; sw_pulse(4'b0100); wait_cyc(5); done_pulse(); wait_cyc(2);
    dly = '0;

    tag = "R9"; prio = '0; sw_pulse(4'b0001); wait_cyc(2);
    sw_pulse(4'b0010); wait_cyc(1); sw_pulse(4'b0010); wait_cyc(2);
    done_pulse(); wait_cyc(3); done_pulse(); wait_cyc(4);

    tag = "R6"; soft_pol = 1'b0; prio = 4'b1000; sw_pulse(4'b1000); wait_cyc(3);
    sw_pulse(4'b0010); wait_cyc(4); done_pulse(); wait_cyc(2);

    tag = "R7"; soft_pol = 1'b1; sw_pulse(4'b1000); wait_cyc(3);
    sw_pulse(4'b0010); wait_cyc(5);
    conv_done = 1'b1; @(negedge clk); conv_done = 1'b0;
    wait_cyc(4); done_pulse(); wait_cyc(2);
    sw_pulse(4'b1000); wait_cyc(3); sw_pulse(4'b0001); wait_cyc(3);
    done_pulse(); wait_cyc(3); done_pulse(); wait_cyc(2);

    tag = "R8"; prio = '0; sw_pulse(4'b1000); wait_cyc(3); sw_pulse(4'b0010);
    wait_cyc(4); done_pulse(); wait_cyc(3); done_pulse(); wait_cyc(3);

    fin = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule